// File: doc/BRIEF.md
# UART Line Status Logic

This block holds the four line status flags of a 16550-style UART: a sticky receive error summary, transmitter empty, transmit holding empty, and break detected. It contains the receive FIFO, whose entries carry the received character plus three tag bits (parity error, framing error, break). It also tracks transmit FIFO occupancy. The serial shifters are outside the block. The receive shifter pushes tagged characters in. The transmit side reports when it loads a character and whether its shift register is still busy. Software reads the status byte through a one-cycle read strobe, and that read clears the flags that are defined as read-to-clear.

With FIFOs disabled, both directions collapse to a single holding register. A programmable THRE mode repurposes the holding-empty flag as a transmit-FIFO-full indication. In that mode the THRE interrupt follows a two-bit occupancy threshold instead of the empty condition.

Top module: `uart_line_status`

## Requirements
- R1: The receive error flag (status bit 7) is set when an entry carrying any of the parity, framing or break tags is accepted into the receive FIFO while FIFOs are enabled. Bit 7 always reads 0 while FIFOs are disabled.
- R2: A status read clears the receive error flag only when no errored entry other than the head entry remains in the receive FIFO. Otherwise the flag stays set.
- R3: Transmitter empty (status bit 6) is 1 exactly when the transmit FIFO or holding register is empty and `tsr_busy` is 0.
- R4: Outside programmable THRE mode, THRE (status bit 5) is 1 exactly when the transmit FIFO or holding register is empty. `thre_irq` equals `thre_ien` AND that empty condition.
- R5: When `pthre_en` and `fifo_en` are both 1, THRE reads 1 exactly when the transmit FIFO holds DEPTH entries. It no longer drives the interrupt.
- R6: In programmable THRE mode, `thre_irq` is `thre_ien` AND (level <= threshold). `tx_thresh` selects the threshold: 00 selects 0 entries, 01 selects 2, 10 selects DEPTH/4 and 11 selects DEPTH/2.
- R7: In FIFO mode, the break flag (status bit 4) is set only after the break-tagged entry becomes the head of the receive FIFO. It is set at most once per head entry.
- R8: In non-FIFO mode, accepting a break-tagged character sets the break flag on that same clock edge. The flag holds until a status read.
- R9: A status read clears the break flag. The read returns the flag value from before the clear.
- R10: After reset, the status byte reads 0x60: transmitter empty and THRE are 1, the error and break flags are 0, and bits 3..0 are always 0.
- R11: When a status read and the acceptance of an errored entry fall in the same cycle, the receive error flag ends up set.
- R12: Both FIFOs hold DEPTH entries in FIFO mode and 1 entry in non-FIFO mode. Writes beyond capacity are ignored, and loads or pops of an empty store are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_en | input | 1 | 1 = FIFO mode, 0 = single holding registers |
| pthre_en | input | 1 | Programmable THRE mode enable |
| thre_ien | input | 1 | THRE interrupt enable |
| tx_thresh | input | 2 | Transmit threshold select (00/01/10/11 = 0/2/DEPTH/4/DEPTH/2) |
| rx_push | input | 1 | Receive shifter delivers a character |
| rx_char | input | DW | Received character |
| rx_perr | input | 1 | Parity error tag of the delivered character |
| rx_ferr | input | 1 | Framing error tag of the delivered character |
| rx_brk | input | 1 | Break tag of the delivered character |
| rx_pop | input | 1 | Software takes the head receive character |
| rx_data | output | DW | Head receive character |
| tx_wr | input | 1 | Software writes a transmit character |
| tx_load | input | 1 | Transmit shifter takes a character |
| tsr_busy | input | 1 | Transmit shift register still sending |
| lsr_rd | input | 1 | Status register read strobe |
| lsr_rdata | output | 8 | Status byte: bit7 error, bit6 TX empty, bit5 THRE, bit4 break |
| thre_irq | output | 1 | THRE interrupt request |

## Verification
The bench places a clean entry ahead of an errored one. A design that clears the error flag on any read loses the pending error, while one that waits for the whole FIFO to drain keeps the flag set after the last error has reached the head. A break-tagged entry queued behind a clean one separates "flag when the character reaches the head" from "flag on arrival". In non-FIFO mode, the flag must appear at once and survive idle cycles. A read that coincides with an errored push exposes a wrong set/clear priority. The transmit side is stepped through every threshold code at and just past its boundary, a write into a full FIFO is checked for being ignored, and THRE is compared between full-flag mode and empty-flag mode.

// File: rtl/uls_pkg.sv
package uls_pkg;

  typedef struct packed {
    logic brk;
    logic ferr;
    logic perr;
  } rx_tag_t;

  localparam int unsigned LSR_ERR_BIT  = 7;
  localparam int unsigned LSR_TEMT_BIT = 6;
  localparam int unsigned LSR_THRE_BIT = 5;
  localparam int unsigned LSR_BRK_BIT  = 4;

  // occupancy at or below which the programmable THRE interrupt fires
  function automatic int unsigned thre_level(input logic [1:0] sel, input int unsigned depth);
    case (sel)
      2'b00:   return 0;
      2'b01:   return 2;
      2'b10:   return depth / 4;
      default: return depth / 2;
    endcase
  endfunction

  function automatic logic tag_has_err(input rx_tag_t t);
    return t.perr | t.ferr | t.brk;
  endfunction

endpackage

// File: rtl/uls_rx_fifo.sv
module uls_rx_fifo
  import uls_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned DW    = 8,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_en,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  rx_tag_t       push_tag,
  input  logic          pop,
  output logic [DW-1:0] head_data,
  output rx_tag_t       head_tag,
  output logic          head_valid,
  output logic [CW-1:0] count,
  output logic [CW-1:0] err_cnt,
  output logic          push_acc,
  output logic          pop_acc
);

  logic [DW-1:0] data_mem [DEPTH];
  rx_tag_t       tag_mem  [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cap;
  logic          push_err, head_err;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign cap        = fifo_en ? CW'(DEPTH) : CW'(1);
  assign push_acc   = push && (count < cap);
  assign pop_acc    = pop && (count != '0);
  assign head_valid = (count != '0);
  assign head_data  = data_mem[rd_ptr];
  assign head_tag   = head_valid ? tag_mem[rd_ptr] : '0;
  assign push_err   = push_acc && tag_has_err(push_tag);
  assign head_err   = pop_acc && tag_has_err(head_tag);

  always_ff @(posedge clk) begin
    if (push_acc) begin
      data_mem[wr_ptr] <= push_data;
      tag_mem[wr_ptr]  <= push_tag;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count   <= '0;
      err_cnt <= '0;
    end else begin
      if (push_acc) wr_ptr <= ptr_next(wr_ptr);
      if (pop_acc)  rd_ptr <= ptr_next(rd_ptr);
      case ({push_acc, pop_acc})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      case ({push_err, head_err})
        2'b10:   err_cnt <= err_cnt + 1'b1;
        2'b01:   err_cnt <= err_cnt - 1'b1;
        default: err_cnt <= err_cnt;
      endcase
    end
  end

endmodule

// File: rtl/uls_tx_track.sv
module uls_tx_track
  import uls_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_en,
  input  logic          pthre_en,
  input  logic          thre_ien,
  input  logic [1:0]    thresh,
  input  logic          wr,
  input  logic          load,
  input  logic          tsr_busy,
  output logic [CW-1:0] level,
  output logic          full,
  output logic          temt,
  output logic          thre,
  output logic          irq
);

  logic [CW-1:0] cap, thr_lvl;
  logic          wr_acc, load_acc, prog_mode, empty;

  assign cap       = fifo_en ? CW'(DEPTH) : CW'(1);
  assign wr_acc    = wr && (level < cap);
  assign load_acc  = load && (level != '0);
  assign prog_mode = pthre_en && fifo_en;
  assign empty     = (level == '0);
  assign full      = (level == CW'(DEPTH));
  assign thr_lvl   = CW'(thre_level(thresh, DEPTH));

  assign temt = empty && !tsr_busy;
  assign thre = prog_mode ? full : empty;
  assign irq  = thre_ien && (prog_mode ? (level <= thr_lvl) : empty);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level <= '0;
    end else begin
      case ({wr_acc, load_acc})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

endmodule

// File: rtl/uls_rx_flags.sv
module uls_rx_flags
  import uls_pkg::*;
#(
  parameter int unsigned CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_en,
  input  logic          lsr_rd,
  input  logic          push_acc,
  input  rx_tag_t       push_tag,
  input  logic          pop_acc,
  input  logic          head_valid,
  input  rx_tag_t       head_tag,
  input  logic [CW-1:0] err_cnt,
  output logic          rfe,
  output logic          bi,
  output logic          rfe_set,
  output logic          rfe_clr,
  output logic          bi_set,
  output logic          head_brk_live
);

  logic          head_seen;
  logic          head_err;
  logic [CW-1:0] others_err;
  logic          brk_at_head, brk_direct;

  assign head_err      = head_valid && tag_has_err(head_tag);
  assign others_err    = err_cnt - CW'(head_err);
  assign head_brk_live = head_valid && head_tag.brk;

  assign rfe_set     = fifo_en && push_acc && tag_has_err(push_tag);
  assign rfe_clr     = lsr_rd && (others_err == '0);
  assign brk_at_head = fifo_en && head_brk_live && !head_seen;
  assign brk_direct  = !fifo_en && push_acc && push_tag.brk;
  assign bi_set      = brk_at_head || brk_direct;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rfe       <= 1'b0;
      bi        <= 1'b0;
      head_seen <= 1'b0;
    end else begin
      if (rfe_set)      rfe <= 1'b1;
      else if (rfe_clr) rfe <= 1'b0;
      if (bi_set)       bi <= 1'b1;
      else if (lsr_rd)  bi <= 1'b0;
      if (pop_acc)          head_seen <= 1'b0;
      else if (brk_at_head) head_seen <= 1'b1;
    end
  end

endmodule

// File: rtl/uart_line_status.sv
module uart_line_status
  import uls_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned DW    = 8,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_en,
  input  logic          pthre_en,
  input  logic          thre_ien,
  input  logic [1:0]    tx_thresh,
  input  logic          rx_push,
  input  logic [DW-1:0] rx_char,
  input  logic          rx_perr,
  input  logic          rx_ferr,
  input  logic          rx_brk,
  input  logic          rx_pop,
  output logic [DW-1:0] rx_data,
  input  logic          tx_wr,
  input  logic          tx_load,
  input  logic          tsr_busy,
  input  logic          lsr_rd,
  output logic [7:0]    lsr_rdata,
  output logic          thre_irq
);

  rx_tag_t       push_tag, head_tag;
  logic          head_valid, push_acc, pop_acc;
  logic [CW-1:0] rx_count, err_cnt, tx_level;
  logic          rfe, bi, rfe_set, rfe_clr, bi_set, head_brk_live;
  logic          tx_full, temt, thre;

  assign push_tag = '{brk: rx_brk, ferr: rx_ferr, perr: rx_perr};

  uls_rx_fifo #(.DEPTH(DEPTH), .DW(DW)) u_rx_fifo (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en),
    .push(rx_push), .push_data(rx_char), .push_tag(push_tag), .pop(rx_pop),
    .head_data(rx_data), .head_tag(head_tag), .head_valid(head_valid),
    .count(rx_count), .err_cnt(err_cnt), .push_acc(push_acc), .pop_acc(pop_acc)
  );

  uls_rx_flags #(.CW(CW)) u_rx_flags (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .lsr_rd(lsr_rd),
    .push_acc(push_acc), .push_tag(push_tag), .pop_acc(pop_acc),
    .head_valid(head_valid), .head_tag(head_tag), .err_cnt(err_cnt),
    .rfe(rfe), .bi(bi), .rfe_set(rfe_set), .rfe_clr(rfe_clr),
    .bi_set(bi_set), .head_brk_live(head_brk_live)
  );

  uls_tx_track #(.DEPTH(DEPTH)) u_tx_track (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .pthre_en(pthre_en),
    .thre_ien(thre_ien), .thresh(tx_thresh), .wr(tx_wr), .load(tx_load),
    .tsr_busy(tsr_busy), .level(tx_level), .full(tx_full),
    .temt(temt), .thre(thre), .irq(thre_irq)
  );

  always_comb begin
    lsr_rdata               = '0;
    lsr_rdata[LSR_ERR_BIT]  = rfe && fifo_en;
    lsr_rdata[LSR_TEMT_BIT] = temt;
    lsr_rdata[LSR_THRE_BIT] = thre;
    lsr_rdata[LSR_BRK_BIT]  = bi;
  end

endmodule

// File: rtl/uart_line_status_chk.sv
module uart_line_status_chk #(
  parameter int unsigned CW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fifo_en,
  input logic          pthre_en,
  input logic          lsr_rd,
  input logic [7:0]    lsr_rdata,
  input logic          thre_irq,
  input logic          rfe,
  input logic          bi,
  input logic          rfe_set,
  input logic          bi_set,
  input logic          head_brk_live,
  input logic          tx_full,
  input logic [CW-1:0] err_cnt,
  input logic [CW-1:0] rx_count
);

  p_err_gated_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_en |-> !lsr_rdata[7]);

  p_err_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    err_cnt <= rx_count);

  p_err_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rfe && !lsr_rd |=> rfe);

  p_temt_implies_thre_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lsr_rdata[6] && !(pthre_en && fifo_en) |-> lsr_rdata[5]);

  p_full_no_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pthre_en && fifo_en && tx_full |-> !thre_irq);

  p_brk_from_head_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bi) && fifo_en && $past(fifo_en) |-> $past(head_brk_live));

  p_brk_read_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lsr_rd && !bi_set |=> !bi);

  p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rfe_set |=> rfe);

  p_low_bits_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    lsr_rdata[3:0] == 4'h0);

endmodule

bind uart_line_status uart_line_status_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .pthre_en(pthre_en),
  .lsr_rd(lsr_rd), .lsr_rdata(lsr_rdata), .thre_irq(thre_irq),
  .rfe(rfe), .bi(bi), .rfe_set(rfe_set), .bi_set(bi_set),
  .head_brk_live(head_brk_live), .tx_full(tx_full),
  .err_cnt(err_cnt), .rx_count(rx_count)
);

// File: tb/uart_line_status_test.sv
`timescale 1ns/1ps
module uart_line_status_test;

  localparam int unsigned DEPTH = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fifo_en = 1'b1, pthre_en = 1'b0, thre_ien = 1'b0;
  logic [1:0] tx_thresh = 2'b00;
  logic       rx_push = 1'b0, rx_perr = 1'b0, rx_ferr = 1'b0, rx_brk = 1'b0, rx_pop = 1'b0;
  logic [7:0] rx_char = 8'h00;
  logic [7:0] rx_data;
  logic       tx_wr = 1'b0, tx_load = 1'b0, tsr_busy = 1'b0, lsr_rd = 1'b0;
  logic [7:0] lsr_rdata;
  logic       thre_irq;

  int n_checks = 0;
  int n_fail   = 0;
  logic [7:0] exp_q [$];
  string      req_q [$];

  always #4 clk = ~clk;

  uart_line_status #(.DEPTH(DEPTH), .DW(8)) uut (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  // monitor: scoreboard compare of every status read
  always @(negedge clk) begin
    if (rst_n && lsr_rd) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "SCOREBOARD", lsr_rdata, 0);
      end else begin
        logic [7:0] e;
        string r;
        e = exp_q.pop_front();
        r = req_q.pop_front();
        check(lsr_rdata == e, r, lsr_rdata, e);
      end
    end
  end

  initial begin
    #(8 * 150000);
    check(1'b0, "WATCHDOG", 0, 1);
    finish_run();
  end

  // driver tasks: start and end at posedge + 2 ns
  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic rd(input logic [7:0] e, input string req);
    exp_q.push_back(e);
    req_q.push_back(req);
    lsr_rd = 1'b1;
    @(posedge clk); #2;
    lsr_rd = 1'b0;
  endtask

  task automatic push(input logic [7:0] d, input logic p, input logic f, input logic b);
    rx_push = 1'b1; rx_char = d; rx_perr = p; rx_ferr = f; rx_brk = b;
    @(posedge clk); #2;
    rx_push = 1'b0; rx_perr = 1'b0; rx_ferr = 1'b0; rx_brk = 1'b0;
  endtask

  task automatic rd_push_err(input logic [7:0] e, input string req);
    exp_q.push_back(e);
    req_q.push_back(req);
    lsr_rd = 1'b1; rx_push = 1'b1; rx_char = 8'h44; rx_ferr = 1'b1;
    @(posedge clk); #2;
    lsr_rd = 1'b0; rx_push = 1'b0; rx_ferr = 1'b0;
  endtask

  task automatic pop();
    rx_pop = 1'b1;
    @(posedge clk); #2;
    rx_pop = 1'b0;
  endtask

  task automatic txw(input int n);
    for (int i = 0; i < n; i++) begin
      tx_wr = 1'b1;
      @(posedge clk); #2;
      tx_wr = 1'b0;
    end
  endtask

  task automatic txl(input int n);
    for (int i = 0; i < n; i++) begin
      tx_load = 1'b1;
      @(posedge clk); #2;
      tx_load = 1'b0;
    end
  endtask

  task automatic chk_irq(input logic e, input string req);
    check(thre_irq == e, req, thre_irq, e);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R10: reset state
    rd(8'h60, "R10 reset status");
    chk_irq(1'b0, "R10 irq off at reset");

    // R3/R4: transmit holding and shift register
    thre_ien = 1'b1;
    idle(1);
    chk_irq(1'b1, "R4 irq when empty");
    txw(1);
    rd(8'h00, "R4 thre cleared by write");
    chk_irq(1'b0, "R4 irq drops with data");
    tsr_busy = 1'b1;
    txl(1);
    rd(8'h20, "R3 thre set but shifter busy");
    chk_irq(1'b1, "R4 irq after load");
    tsr_busy = 1'b0;
    idle(1);
    rd(8'h60, "R3 temt after shifter idle");

    // R5/R6/R12: programmable THRE mode
    pthre_en = 1'b1; tx_thresh = 2'b01;
    txw(DEPTH + 1);
    rd(8'h20, "R5 thre shows full");
    chk_irq(1'b0, "R6 irq off above 2");
    pthre_en = 1'b0;
    idle(1);
    rd(8'h00, "R5 normal mode thre not empty");
    pthre_en = 1'b1;
    txl(DEPTH - 2);
    chk_irq(1'b1, "R6 irq at level 2 code 01");
    rd(8'h00, "R5 thre clear when not full");
    txl(1);
    tx_thresh = 2'b00;
    idle(1);
    chk_irq(1'b0, "R6 irq off at level 1 code 00");
    txl(1);
    chk_irq(1'b1, "R12 extra write ignored, level 0");
    tx_thresh = 2'b10;
    txw(4);
    chk_irq(1'b1, "R6 irq at quarter");
    txw(1);
    chk_irq(1'b0, "R6 irq off above quarter");
    tx_thresh = 2'b11;
    txw(3);
    chk_irq(1'b1, "R6 irq at half");
    txw(1);
    chk_irq(1'b0, "R6 irq off above half");
    pthre_en = 1'b0;
    txl(DEPTH / 2 + 1);
    rd(8'h60, "R4 empty after drain");
    chk_irq(1'b1, "R4 irq back on empty");

    // R12: non-FIFO transmit capacity
    fifo_en = 1'b0;
    txw(2);
    txl(1);
    rd(8'h60, "R12 tx holding register holds one");

    // R12: non-FIFO receive capacity
    push(8'h11, 1'b0, 1'b0, 1'b0);
    push(8'h22, 1'b0, 1'b0, 1'b0);
    check(rx_data == 8'h11, "R12 second rx push ignored", rx_data, 8'h11);
    pop();
    // R1: error flag hidden without FIFOs
    push(8'h33, 1'b1, 1'b0, 1'b0);
    idle(1);
    rd(8'h60, "R1 error bit zero in non-fifo");
    pop();
    fifo_en = 1'b1;
    idle(1);

    // R1/R2: error pending behind the head
    push(8'h41, 1'b0, 1'b0, 1'b0);
    push(8'h42, 1'b1, 1'b0, 1'b0);
    push(8'h43, 1'b0, 1'b0, 1'b0);
    idle(1);
    rd(8'hE0, "R1 error flag set");
    rd(8'hE0, "R2 flag kept, error behind head");
    pop();
    idle(1);
    rd(8'hE0, "R2 read with errored head");
    rd(8'hE0 & 8'h7F, "R2 cleared when only head errored");
    // R11: set beats clear
    rd_push_err(8'h60, "R11 read value before set");
    rd(8'hE0, "R11 set kept over clear");
    rd(8'hE0, "R2 later error still queued");
    pop();
    pop();
    idle(1);
    rd(8'hE0, "R2 last error now at head");
    rd(8'h60, "R2 flag cleared");
    pop();
    idle(1);

    // R7/R9: break in FIFO mode waits for head
    push(8'h51, 1'b0, 1'b0, 1'b0);
    push(8'h00, 1'b0, 1'b0, 1'b1);
    idle(2);
    rd(8'hE0, "R7 break not yet at head");
    pop();
    idle(2);
    check(rx_data == 8'h00, "R7 break character is zero", rx_data, 8'h00);
    rd(8'hF0, "R7 break flag at head");
    rd(8'h60, "R9 read cleared break");
    idle(2);
    rd(8'h60, "R7 no second break for same head");
    pop();
    idle(1);

    // R8: non-FIFO break shows at once and holds
    fifo_en = 1'b0;
    push(8'h00, 1'b0, 1'b0, 1'b1);
    rd(8'h70, "R8 break visible next cycle");
    push(8'h00, 1'b0, 1'b0, 1'b0);
    pop();
    push(8'h00, 1'b0, 1'b0, 1'b1);
    idle(6);
    rd(8'h70, "R8 break held until read");
    rd(8'h60, "R9 break cleared by read");
    pop();
    idle(2);

    finish_run();
  end

endmodule